// File: doc/BRIEF.md
# Multicycle Fetch-Execute Sequencer

This block is the control unit and datapath of a small multicycle processor. Every instruction is taken through the same ordered phases: fetch, decode, operand fetch and execute. During fetch the block puts its program counter on the memory address bus with a read strobe. It waits one cycle for the synchronous memory to answer, then captures the returned word in its instruction register and advances the program counter by one instruction width.

Only two behaviours are defined: a move of an immediate into a destination, and a no-op for every other opcode. The move routes its immediate through a pass-through ALU and writes the result in execute. The program counter is one of the legal destinations. Writing it discards the value incremented during fetch, so the next fetch starts at the written address, which makes a jump. A debug read port on the register file, and debug outputs for the phase, program counter and instruction register, let a bench follow the sequence.

The state machine has five states. ST_FETCH_ADDR drives the strobe. ST_FETCH_WAIT captures the word and increments the PC. ST_DECODE latches the decoded fields. ST_OPERAND loads the ALU operand. ST_EXECUTE writes the destination. The transitions run FETCH_ADDR → FETCH_WAIT → DECODE → OPERAND → EXECUTE → FETCH_ADDR unconditionally, and reset forces FETCH_ADDR.

Top module: `fetch_exec_seq`

## Requirements
- R1: The phase output `dbg_phase` (0 fetch, 1 decode, 2 operand fetch, 3 execute) holds fetch for two cycles, then shows decode, operand fetch and execute for one cycle each, then returns to fetch.
- R2: In the first fetch cycle `mem_rd` is 1 and `mem_addr` equals the PC. `mem_rd` is 1 for exactly that one cycle per instruction.
- R3: The word on `mem_rdata` in the cycle after the strobe is captured in the instruction register and appears on `dbg_ir` from decode onward.
- R4: The PC increases by 4 at the end of fetch and shows the new value from decode onward.
- R5: Encoding: opcode in bits 31:28, where 0x1 means move-immediate; destination code in bits 27:24, where 0xF names the PC and codes below the register count name file registers; immediate in bits 23:0, zero-extended.
- R6: A move to register code n writes the zero-extended immediate, passed unchanged through the ALU, into register n, readable through `rf_sel`/`rf_data`.
- R7: A move to destination 0xF replaces the incremented PC with the immediate, so the next fetch address is the immediate (for example 4 after fetching from 44).
- R8: An instruction with an opcode other than 0x1 changes neither the PC beyond its increment nor any register, even if its destination field is 0xF.
- R9: A move whose destination code is neither 0xF nor a valid register index writes nothing.
- R10: Synchronous active-high reset sets the PC to 0, the phase to fetch and all registers to 0, and holds `mem_rd` low while asserted. The first fetch after release reads address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Fetch address, equal to the PC |
| mem_rd | output | 1 | Read strobe, high in the first fetch cycle |
| mem_rdata | input | 32 | Memory read data, valid one cycle after the strobe |
| rf_sel | input | 2 | Register file debug read index |
| rf_data | output | 32 | Contents of the selected register |
| dbg_phase | output | 2 | Current phase code |
| dbg_pc | output | 32 | Program counter |
| dbg_ir | output | 32 | Instruction register |

## Verification
A state register that skips or repeats a state shifts the strobe and the phase code at once. The error shows within one instruction period of five cycles, as a strobe at the wrong distance from the previous one. A wrong PC update shows two cycles after the strobe on `dbg_pc`, and at the latest on `mem_addr` at the next strobe. A misrouted register write stays hidden until the register is read back through `rf_sel`, so each written and untouched register is read once the program has run.

// File: rtl/fetch_exec_seq_pkg.sv
package fetch_exec_seq_pkg;

    localparam int WORD_W  = 32;
    localparam int OPC_W   = 4;
    localparam int DST_W   = 4;
    localparam int IMM_W   = WORD_W - OPC_W - DST_W;
    localparam int OPC_LSB = WORD_W - OPC_W;
    localparam int DST_LSB = IMM_W;

    localparam logic [OPC_W-1:0] OPC_MOVI = 4'h1;
    localparam logic [DST_W-1:0] DST_PC   = {DST_W{1'b1}};

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_WAIT,
        ST_DECODE,
        ST_OPERAND,
        ST_EXECUTE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_FETCH   = 2'd0,
        PH_DECODE  = 2'd1,
        PH_OPERAND = 2'd2,
        PH_EXECUTE = 2'd3
    } seq_phase_e;

    typedef struct packed {
        logic             wr_reg;
        logic             wr_pc;
        logic [DST_W-1:0] dest;
        logic [IMM_W-1:0] imm;
    } dec_fields_s;

endpackage

// File: rtl/seq_decoder.sv
module seq_decoder
    import fetch_exec_seq_pkg::*;
#(
    parameter int REG_NUM = 4
) (
    input  logic [WORD_W-1:0] instr_i,
    output dec_fields_s       dec_o
);
    logic [OPC_W-1:0] opc;
    logic             is_movi;

    always_comb begin
        opc          = instr_i[OPC_LSB +: OPC_W];
        is_movi      = (opc == OPC_MOVI);
        dec_o.dest   = instr_i[DST_LSB +: DST_W];
        dec_o.imm    = instr_i[IMM_W-1:0];
        dec_o.wr_pc  = is_movi && (dec_o.dest == DST_PC);
        dec_o.wr_reg = is_movi && (int'(dec_o.dest) < REG_NUM);
    end
endmodule

// File: rtl/seq_alu.sv
module seq_alu
    import fetch_exec_seq_pkg::*;
(
    input  logic [WORD_W-1:0] operand_i,
    output logic [WORD_W-1:0] result_o
);
    // Move is the only operation: the operand passes straight through.
    always_comb result_o = operand_i;
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile
    import fetch_exec_seq_pkg::*;
#(
    parameter int REG_NUM = 4,
    localparam int IDX_W  = (REG_NUM > 1) ? $clog2(REG_NUM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DST_W-1:0]  wr_idx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [WORD_W-1:0] rd_data_o
);
    logic [WORD_W-1:0] regs [REG_NUM];

    for (genvar g = 0; g < REG_NUM; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == DST_W'(g))) begin
                regs[g] <= wr_data_i;
            end
        end
    end

    always_comb rd_data_o = regs[rd_idx_i];
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
    import fetch_exec_seq_pkg::*;
#(
    parameter int REG_NUM     = 4,
    parameter int INSTR_BYTES = 4,
    localparam int REG_IDX_W  = (REG_NUM > 1) ? $clog2(REG_NUM) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [WORD_W-1:0]    mem_addr,
    output logic                 mem_rd,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic [REG_IDX_W-1:0] rf_sel,
    output logic [WORD_W-1:0]    rf_data,
    output logic [1:0]           dbg_phase,
    output logic [WORD_W-1:0]    dbg_pc,
    output logic [WORD_W-1:0]    dbg_ir
);
    seq_state_e        state_q, state_d;
    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] ir_q;
    logic [WORD_W-1:0] opnd_q;
    logic [WORD_W-1:0] alu_y;
    dec_fields_s       dec_w, dec_q;
    logic              rf_we;

    seq_decoder #(.REG_NUM(REG_NUM)) u_dec (
        .instr_i (ir_q),
        .dec_o   (dec_w)
    );

    seq_alu u_alu (
        .operand_i (opnd_q),
        .result_o  (alu_y)
    );

    seq_regfile #(.REG_NUM(REG_NUM)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (rf_we),
        .wr_idx_i  (dec_q.dest),
        .wr_data_i (alu_y),
        .rd_idx_i  (rf_sel),
        .rd_data_o (rf_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH_ADDR;
        else     state_q <= state_d;
    end

    // Transitions: a fixed ring of five states
    always_comb begin
        unique case (state_q)
            ST_FETCH_ADDR: state_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT: state_d = ST_DECODE;
            ST_DECODE:     state_d = ST_OPERAND;
            ST_OPERAND:    state_d = ST_EXECUTE;
            ST_EXECUTE:    state_d = ST_FETCH_ADDR;
            default:       state_d = ST_FETCH_ADDR;
        endcase
    end

    // Datapath registers, loaded per state
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ir_q   <= '0;
            dec_q  <= '0;
            opnd_q <= '0;
        end else begin
            unique case (state_q)
                ST_FETCH_WAIT: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + WORD_W'(INSTR_BYTES);
                end
                ST_DECODE:  dec_q  <= dec_w;
                ST_OPERAND: opnd_q <= WORD_W'(dec_q.imm);
                ST_EXECUTE: if (dec_q.wr_pc) pc_q <= alu_y;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_addr = pc_q;
        mem_rd   = 1'b0;
        rf_we    = 1'b0;
        unique case (state_q)
            ST_FETCH_ADDR: begin
                mem_rd    = !rst;
                dbg_phase = PH_FETCH;
            end
            ST_FETCH_WAIT: dbg_phase = PH_FETCH;
            ST_DECODE:     dbg_phase = PH_DECODE;
            ST_OPERAND:    dbg_phase = PH_OPERAND;
            ST_EXECUTE: begin
                dbg_phase = PH_EXECUTE;
                rf_we     = dec_q.wr_reg;
            end
            default:       dbg_phase = PH_FETCH;
        endcase
        dbg_pc = pc_q;
        dbg_ir = ir_q;
    end
endmodule

// File: rtl/fetch_exec_seq_chk.sv
module fetch_exec_seq_chk
    import fetch_exec_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic [WORD_W-1:0] mem_rdata,
    input logic [1:0]        dbg_phase,
    input logic [WORD_W-1:0] dbg_pc,
    input logic [WORD_W-1:0] dbg_ir
);
    logic ex_movi_pc;
    logic ex_not_movi;
    always_comb begin
        ex_movi_pc  = (dbg_phase == PH_EXECUTE) &&
                      (dbg_ir[OPC_LSB +: OPC_W] == OPC_MOVI) &&
                      (dbg_ir[DST_LSB +: DST_W] == DST_PC);
        ex_not_movi = (dbg_phase == PH_EXECUTE) &&
                      (dbg_ir[OPC_LSB +: OPC_W] != OPC_MOVI);
    end

    assert_phase_order_R1: assert property (@(posedge clk) disable iff (rst)
        (dbg_phase == PH_DECODE) |=> (dbg_phase == PH_OPERAND));
    assert_exec_follows_R1: assert property (@(posedge clk) disable iff (rst)
        (dbg_phase == PH_OPERAND) |=> (dbg_phase == PH_EXECUTE));
    assert_fetch_follows_R1: assert property (@(posedge clk) disable iff (rst)
        (dbg_phase == PH_EXECUTE) |=> (dbg_phase == PH_FETCH) && mem_rd);
    assert_strobe_addr_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (dbg_phase == PH_FETCH) && (mem_addr == dbg_pc));
    assert_strobe_wait_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd && (dbg_phase == PH_FETCH));
    assert_ir_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (dbg_phase == PH_FETCH && !mem_rd) |=>
            (dbg_phase == PH_DECODE) && (dbg_ir == $past(mem_rdata)));
    assert_pc_incr_R4: assert property (@(posedge clk) disable iff (rst)
        (dbg_phase == PH_FETCH && !mem_rd) |=> (dbg_pc == $past(dbg_pc) + 32'd4));
    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (dbg_phase == PH_OPERAND) |-> $stable(dbg_pc));
    assert_pc_jump_R7: assert property (@(posedge clk) disable iff (rst)
        ex_movi_pc |=> (dbg_pc == WORD_W'($past(dbg_ir[IMM_W-1:0]))));
    assert_nop_pc_R8: assert property (@(posedge clk) disable iff (rst)
        ex_not_movi |=> $stable(dbg_pc));
    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |-> !mem_rd);
    assert_reset_state_R10: assert property (@(posedge clk)
        $past(rst) |-> (dbg_pc == '0) && (dbg_phase == PH_FETCH));
endmodule

bind fetch_exec_seq fetch_exec_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .dbg_phase (dbg_phase),
    .dbg_pc    (dbg_pc),
    .dbg_ir    (dbg_ir)
);

// File: tb/fetch_exec_seq_test.sv
`timescale 1ns/1ps
module fetch_exec_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  rf_sel = '0;
    logic [31:0] rf_data;
    logic [1:0]  dbg_phase;
    logic [31:0] dbg_pc;
    logic [31:0] dbg_ir;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] mem [64];

    always #2 clk = ~clk;

    fetch_exec_seq uut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .rf_sel    (rf_sel),
        .rf_data   (rf_data),
        .dbg_phase (dbg_phase),
        .dbg_pc    (dbg_pc),
        .dbg_ir    (dbg_ir)
    );

    // Synchronous read memory, one cycle of latency
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:2]];

    // {fetch address, instruction word, expected PC after execute}
    localparam logic [95:0] VEC [9] = '{
        {32'd0,   32'h1F000028, 32'd40 },  // move 40 into PC
        {32'd40,  32'h00000000, 32'd44 },  // no-op
        {32'd44,  32'h1F000004, 32'd4  },  // move 4 into PC: 44 -> 4
        {32'd4,   32'h11000123, 32'd8  },  // move into register 1
        {32'd8,   32'h7F000010, 32'd12 },  // unknown opcode, PC field
        {32'd12,  32'h15000008, 32'd16 },  // move to unused code 5
        {32'd16,  32'h12ABCDEF, 32'd20 },  // move into register 2
        {32'd20,  32'h1F0000FC, 32'd252},  // move 252 into PC
        {32'd252, 32'h13000055, 32'd256}   // move into register 3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_reg(input logic [1:0] idx, input logic [31:0] exp, input string req);
        rf_sel = idx;
        #0.5;
        check(req, rf_data, exp);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        for (int i = 0; i < 9; i++) mem[VEC[i][95:66]] = VEC[i][63:32];

        rst = 1'b1;
        step(3);
        check("R10 reset strobe", {31'b0, mem_rd}, 32'd0);
        check("R10 reset pc", dbg_pc, 32'd0);
        check("R10 reset phase", {30'b0, dbg_phase}, 32'd0);
        rst = 1'b0;
        #0.5;

        for (int v = 0; v < 9; v++) begin
            // first fetch cycle: strobe and address; PC from previous execute (R7 R8 R9)
            check("R2 strobe", {31'b0, mem_rd}, 32'd1);
            check("R2 address", mem_addr, VEC[v][95:64]);
            if (v > 0) check("R7 R8 next pc", dbg_pc, VEC[v-1][31:0]);
            step(1);
            check("R2 single strobe", {31'b0, mem_rd}, 32'd0);
            check("R1 fetch wait", {30'b0, dbg_phase}, 32'd0);
            step(1);
            check("R1 decode", {30'b0, dbg_phase}, 32'd1);
            check("R3 ir", dbg_ir, VEC[v][63:32]);
            check("R4 pc plus 4", dbg_pc, VEC[v][95:64] + 32'd4);
            step(1);
            check("R1 operand", {30'b0, dbg_phase}, 32'd2);
            step(1);
            check("R1 execute", {30'b0, dbg_phase}, 32'd3);
            step(1);
        end
        check("R7 last pc", dbg_pc, 32'd256);

        read_reg(2'd1, 32'h00000123, "R6 R9 reg1");
        read_reg(2'd2, 32'h00ABCDEF, "R5 R6 reg2");
        read_reg(2'd3, 32'h00000055, "R6 reg3");
        read_reg(2'd0, 32'h00000000, "R8 R9 reg0");

        // Reset in the middle of an instruction
        step(2);
        check("R1 decode before reset", {30'b0, dbg_phase}, 32'd1);
        rst = 1'b1;
        #0.5;
        check("R10 strobe held low", {31'b0, mem_rd}, 32'd0);
        step(1);
        check("R10 pc cleared", dbg_pc, 32'd0);
        check("R10 phase fetch", {30'b0, dbg_phase}, 32'd0);
        read_reg(2'd1, 32'd0, "R10 reg1 cleared");
        read_reg(2'd2, 32'd0, "R10 reg2 cleared");
        rst = 1'b0;
        #0.5;
        check("R10 first fetch strobe", {31'b0, mem_rd}, 32'd1);
        check("R10 first fetch address", mem_addr, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule